// File: doc/BRIEF.md
# Dual-Port Inter-Processor Mailbox

This block lets two processors that share one clock exchange 32-bit words in both directions. Each processor owns an AXI4-Lite slave port. Two independent word queues sit between the ports, one for each direction. A word written to a port's send register is placed in the queue that the opposite port drains through its receive register. The queue depth is set when the block is built.

Each port has a status register that shows whether its incoming and outgoing queues are empty or full. Each port also has an interrupt enable bit. Each side has an interrupt line that stays high while its enable bit is set and words are waiting for it. A processor that writes to a full queue, or reads from an empty one, gets an error response. The queues are left unchanged when that happens.

Top module: `dual_mailbox`

## Requirements
- R1: After reset both queues are empty, both interrupt enable bits are 0, and both interrupt outputs are low.
- R2: A write to offset 0x0 on one port appends the word to the queue towards the other port. Reads of offset 0x4 on the other port return the queued words in the order they were written. The two directions are independent of each other.
- R3: Each queue holds exactly DEPTH words. After DEPTH writes with no reads, the queue reports full to both of its ports.
- R4: A write to offset 0x0 while the outgoing queue is full is discarded and answered with SLVERR (2'b10). Accepted writes are answered with OKAY (2'b00).
- R5: A read of offset 0x4 while the incoming queue is empty returns data 0 with SLVERR (2'b10) and does not change any queue.
- R6: A read of offset 0x8 returns a status word: bit0 = incoming queue empty, bit1 = incoming queue full, bit2 = outgoing queue empty, bit3 = outgoing queue full, and all other bits 0.
- R7: Offset 0xC is a read/write interrupt enable register. Only bit0 is stored, and it reads back in bit0 with all other bits 0.
- R8: A port's interrupt output is high exactly while its enable bit is 1 and its incoming queue is not empty. It goes low once that queue has been drained.
- R9: When one port enqueues and the other port dequeues the same queue in the same cycle, both operations complete and the occupancy stays consistent.
- R10: Each port accepts one write and one read at a time. A response stays valid with stable contents until the manager accepts it, and no new request is accepted while a response is pending.
- R11: Writes to offsets 0x4 and 0x8 are answered with OKAY and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_awaddr | input | 4 | Port A write address (byte offset) |
| a_awvalid | input | 1 | Port A write address valid |
| a_awready | output | 1 | Port A write address ready |
| a_wdata | input | 32 | Port A write data |
| a_wvalid | input | 1 | Port A write data valid |
| a_wready | output | 1 | Port A write data ready |
| a_bresp | output | 2 | Port A write response |
| a_bvalid | output | 1 | Port A write response valid |
| a_bready | input | 1 | Port A write response ready |
| a_araddr | input | 4 | Port A read address (byte offset) |
| a_arvalid | input | 1 | Port A read address valid |
| a_arready | output | 1 | Port A read address ready |
| a_rdata | output | 32 | Port A read data |
| a_rresp | output | 2 | Port A read response |
| a_rvalid | output | 1 | Port A read data valid |
| a_rready | input | 1 | Port A read data ready |
| irq_a | output | 1 | Interrupt to processor A |
| b_awaddr | input | 4 | Port B write address (byte offset) |
| b_awvalid | input | 1 | Port B write address valid |
| b_awready | output | 1 | Port B write address ready |
| b_wdata | input | 32 | Port B write data |
| b_wvalid | input | 1 | Port B write data valid |
| b_wready | output | 1 | Port B write data ready |
| b_bresp | output | 2 | Port B write response |
| b_bvalid | output | 1 | Port B write response valid |
| b_bready | input | 1 | Port B write response ready |
| b_araddr | input | 4 | Port B read address (byte offset) |
| b_arvalid | input | 1 | Port B read address valid |
| b_arready | output | 1 | Port B read address ready |
| b_rdata | output | 32 | Port B read data |
| b_rresp | output | 2 | Port B read response |
| b_rvalid | output | 1 | Port B read data valid |
| b_rready | input | 1 | Port B read data ready |
| irq_b | output | 1 | Interrupt to processor B |

## Verification
The assertions assume that each manager presents the write address and write data together and holds both until they are accepted. They also assume that the manager does not lower a valid signal before its handshake completes. The bench's access tasks follow these rules: they raise the address and data valids together at a falling edge and drop them only after the rising edge that accepts them. Each task starts a new access only after the previous response has been taken. The simultaneous-access scenario launches one access on each port from the same falling edge, so the enqueue and the dequeue land on the same rising edge.

// File: rtl/mbox_pkg.sv
// Shared definitions for the dual-port mailbox.
// Assumes word-aligned 4-bit byte offsets. Bits [3:2] select the register.
package mbox_pkg;

    // Register selected by address bits [3:2]
    typedef enum logic [1:0] {
        REG_TX   = 2'd0,
        REG_RX   = 2'd1,
        REG_STAT = 2'd2,
        REG_IEN  = 2'd3
    } reg_sel_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/mbox_fifo.sv
// One-direction word queue with a registered occupancy count.
// The head word is visible combinationally while the queue is not empty.
// Assumes the caller never pushes when full and never pops when empty.
// Any DEPTH >= 1 is allowed; the pointers wrap explicitly.
module mbox_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;

    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);
    assign head  = mem[rd_ptr];

    // Storage write at the tail slot
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Tail pointer advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (push) begin
            wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Head pointer advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (pop) begin
            rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Occupancy tracking; a push and a pop together leave it unchanged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R5
    AST_SAME_CYCLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count)); // R9
    AST_COUNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count == $past(count) + 1'b1)); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R3

endmodule

// File: rtl/mbox_port.sv
// AXI4-Lite slave front end for one processor.
// Decodes the four registers, pushes into the outgoing queue, pops the
// incoming queue, and holds the interrupt enable bit.
// Assumes full-word accesses and that write address and data arrive together.
module mbox_port
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic              tx_full,
    input  logic              tx_empty,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic [DATA_W-1:0] rx_head,
    output logic              rx_pop,
    output logic              irq
);
    logic     wr_go;
    logic     rd_go;
    reg_sel_e wr_sel;
    reg_sel_e rd_sel;
    logic     ien;
    logic     unused_addr_bits;

    assign unused_addr_bits = ^{awaddr[1:0], araddr[1:0]};

    // Request acceptance: one outstanding access per channel
    assign wr_go   = awvalid && wvalid && !bvalid;
    assign awready = wr_go;
    assign wready  = wr_go;
    assign rd_go   = arvalid && !rvalid;
    assign arready = rd_go;

    assign wr_sel  = reg_sel_e'(awaddr[3:2]);
    assign rd_sel  = reg_sel_e'(araddr[3:2]);

    // Queue side effects of accepted accesses
    assign tx_push = wr_go && (wr_sel == REG_TX) && !tx_full;
    assign tx_data = wdata;
    assign rx_pop  = rd_go && (rd_sel == REG_RX) && !rx_empty;

    // Interrupt while enabled and words are waiting
    assign irq = ien && !rx_empty;

    // Write response channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid <= 1'b0;
            bresp  <= RESP_OKAY;
        end else if (wr_go) begin
            bvalid <= 1'b1;
            bresp  <= ((wr_sel == REG_TX) && tx_full) ? RESP_SLVERR : RESP_OKAY;
        end else if (bready) begin
            bvalid <= 1'b0;
        end
    end

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= 1'b0;
        end else if (wr_go && (wr_sel == REG_IEN)) begin
            ien <= wdata[0];
        end
    end

    // Read data channel with register decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
            rresp  <= RESP_OKAY;
        end else if (rd_go) begin
            rvalid <= 1'b1;
            rresp  <= RESP_OKAY;
            unique case (rd_sel)
                REG_RX: begin
                    if (rx_empty) begin
                        rdata <= '0;
                        rresp <= RESP_SLVERR;
                    end else begin
                        rdata <= rx_head;
                    end
                end
                REG_STAT: rdata <= DATA_W'({tx_full, tx_empty, rx_full, rx_empty});
                REG_IEN:  rdata <= DATA_W'(ien);
                default:  rdata <= '0;
            endcase
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    AST_BRESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bresp))); // R10
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp))); // R10
    AST_FULL_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && (wr_sel == REG_TX) && tx_full) |=> (bresp == RESP_SLVERR)); // R4
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && (rd_sel == REG_RX) && rx_empty) |=> (rdata == '0 && rresp == RESP_SLVERR)); // R5
    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty && rx_full) && !(tx_empty && tx_full)); // R6

endmodule

// File: rtl/dual_mailbox.sv
// Two-port mailbox: each AXI4-Lite port feeds the queue towards the peer
// and drains the queue coming from the peer.
// Assumes one clock shared by both processors.
module dual_mailbox #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_awaddr,
    input  logic              a_awvalid,
    output logic              a_awready,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_wvalid,
    output logic              a_wready,
    output logic [1:0]        a_bresp,
    output logic              a_bvalid,
    input  logic              a_bready,
    input  logic [ADDR_W-1:0] a_araddr,
    input  logic              a_arvalid,
    output logic              a_arready,
    output logic [DATA_W-1:0] a_rdata,
    output logic [1:0]        a_rresp,
    output logic              a_rvalid,
    input  logic              a_rready,
    output logic              irq_a,
    input  logic [ADDR_W-1:0] b_awaddr,
    input  logic              b_awvalid,
    output logic              b_awready,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_wvalid,
    output logic              b_wready,
    output logic [1:0]        b_bresp,
    output logic              b_bvalid,
    input  logic              b_bready,
    input  logic [ADDR_W-1:0] b_araddr,
    input  logic              b_arvalid,
    output logic              b_arready,
    output logic [DATA_W-1:0] b_rdata,
    output logic [1:0]        b_rresp,
    output logic              b_rvalid,
    input  logic              b_rready,
    output logic              irq_b
);
    logic              ab_push, ab_pop, ab_empty, ab_full;
    logic [DATA_W-1:0] ab_data, ab_head;
    logic              ba_push, ba_pop, ba_empty, ba_full;
    logic [DATA_W-1:0] ba_data, ba_head;

    // Queue carrying words from A to B
    mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_a2b (
        .clk(clk), .rst_n(rst_n),
        .push(ab_push), .push_data(ab_data), .pop(ab_pop),
        .head(ab_head), .empty(ab_empty), .full(ab_full)
    );

    // Queue carrying words from B to A
    mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_b2a (
        .clk(clk), .rst_n(rst_n),
        .push(ba_push), .push_data(ba_data), .pop(ba_pop),
        .head(ba_head), .empty(ba_empty), .full(ba_full)
    );

    // Front end for processor A
    mbox_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port_a (
        .clk(clk), .rst_n(rst_n),
        .awaddr(a_awaddr), .awvalid(a_awvalid), .awready(a_awready),
        .wdata(a_wdata), .wvalid(a_wvalid), .wready(a_wready),
        .bresp(a_bresp), .bvalid(a_bvalid), .bready(a_bready),
        .araddr(a_araddr), .arvalid(a_arvalid), .arready(a_arready),
        .rdata(a_rdata), .rresp(a_rresp), .rvalid(a_rvalid), .rready(a_rready),
        .tx_full(ab_full), .tx_empty(ab_empty), .tx_push(ab_push), .tx_data(ab_data),
        .rx_empty(ba_empty), .rx_full(ba_full), .rx_head(ba_head), .rx_pop(ba_pop),
        .irq(irq_a)
    );

    // Front end for processor B
    mbox_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port_b (
        .clk(clk), .rst_n(rst_n),
        .awaddr(b_awaddr), .awvalid(b_awvalid), .awready(b_awready),
        .wdata(b_wdata), .wvalid(b_wvalid), .wready(b_wready),
        .bresp(b_bresp), .bvalid(b_bvalid), .bready(b_bready),
        .araddr(b_araddr), .arvalid(b_arvalid), .arready(b_arready),
        .rdata(b_rdata), .rresp(b_rresp), .rvalid(b_rvalid), .rready(b_rready),
        .tx_full(ba_full), .tx_empty(ba_empty), .tx_push(ba_push), .tx_data(ba_data),
        .rx_empty(ab_empty), .rx_full(ab_full), .rx_head(ab_head), .rx_pop(ab_pop),
        .irq(irq_b)
    );

    AST_IRQ_A_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ba_empty |-> !irq_a); // R8
    AST_IRQ_B_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ab_empty |-> !irq_b); // R8

endmodule

// File: tb/test_dual_mailbox.sv
// Directed bench for the dual-port mailbox: one task per scenario.
module test_dual_mailbox;
    localparam int DEPTH = 4;
    localparam logic [1:0] OKAY = 2'b00;
    localparam logic [1:0] SLVERR = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  a_awaddr = '0, b_awaddr = '0, a_araddr = '0, b_araddr = '0;
    logic        a_awvalid = 0, b_awvalid = 0, a_wvalid = 0, b_wvalid = 0;
    logic        a_arvalid = 0, b_arvalid = 0;
    logic        a_bready = 1, b_bready = 1, a_rready = 1, b_rready = 1;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic        a_awready, a_wready, a_bvalid, a_arready, a_rvalid, irq_a;
    logic        b_awready, b_wready, b_bvalid, b_arready, b_rvalid, irq_b;
    logic [1:0]  a_bresp, a_rresp, b_bresp, b_rresp;
    logic [31:0] a_rdata, b_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_mailbox #(.DATA_W(32), .DEPTH(DEPTH), .ADDR_W(4)) i_dual_mailbox (
        .clk(clk), .rst_n(rst_n),
        .a_awaddr(a_awaddr), .a_awvalid(a_awvalid), .a_awready(a_awready),
        .a_wdata(a_wdata), .a_wvalid(a_wvalid), .a_wready(a_wready),
        .a_bresp(a_bresp), .a_bvalid(a_bvalid), .a_bready(a_bready),
        .a_araddr(a_araddr), .a_arvalid(a_arvalid), .a_arready(a_arready),
        .a_rdata(a_rdata), .a_rresp(a_rresp), .a_rvalid(a_rvalid), .a_rready(a_rready),
        .irq_a(irq_a),
        .b_awaddr(b_awaddr), .b_awvalid(b_awvalid), .b_awready(b_awready),
        .b_wdata(b_wdata), .b_wvalid(b_wvalid), .b_wready(b_wready),
        .b_bresp(b_bresp), .b_bvalid(b_bvalid), .b_bready(b_bready),
        .b_araddr(b_araddr), .b_arvalid(b_arvalid), .b_arready(b_arready),
        .b_rdata(b_rdata), .b_rresp(b_rresp), .b_rvalid(b_rvalid), .b_rready(b_rready),
        .irq_b(irq_b)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Single write on port p (0 = A, 1 = B); returns the response code
    task automatic bus_wr(input int p, input logic [3:0] addr, input logic [31:0] data,
                          output logic [1:0] resp);
        @(negedge clk);
        if (p == 0) begin
            a_awaddr = addr; a_wdata = data; a_awvalid = 1; a_wvalid = 1; a_bready = 1;
        end else begin
            b_awaddr = addr; b_wdata = data; b_awvalid = 1; b_wvalid = 1; b_bready = 1;
        end
        @(posedge clk);
        @(negedge clk);
        if (p == 0) begin
            a_awvalid = 0; a_wvalid = 0; resp = a_bresp;
        end else begin
            b_awvalid = 0; b_wvalid = 0; resp = b_bresp;
        end
    endtask

    // Single read on port p; returns data and response code
    task automatic bus_rd(input int p, input logic [3:0] addr, output logic [31:0] data,
                          output logic [1:0] resp);
        @(negedge clk);
        if (p == 0) begin
            a_araddr = addr; a_arvalid = 1; a_rready = 1;
        end else begin
            b_araddr = addr; b_arvalid = 1; b_rready = 1;
        end
        @(posedge clk);
        @(negedge clk);
        if (p == 0) begin
            a_arvalid = 0; data = a_rdata; resp = a_rresp;
        end else begin
            b_arvalid = 0; data = b_rdata; resp = b_rresp;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [1:0] r;
        chk("R1", "irq_a after reset", 32'(irq_a), 0);
        chk("R1", "irq_b after reset", 32'(irq_b), 0);
        bus_rd(0, 4'h8, d, r); chk("R1", "A status after reset", d, 32'h5);
        bus_rd(1, 4'h8, d, r); chk("R6", "B status after reset", d, 32'h5);
        bus_rd(0, 4'hC, d, r); chk("R7", "A enable after reset", d, 0);
        bus_rd(1, 4'hC, d, r); chk("R1", "B enable after reset", d, 0);
    endtask

    task automatic t_transfer();
        logic [31:0] d; logic [1:0] r;
        for (int i = 0; i < 3; i++) begin
            bus_wr(0, 4'h0, 32'h1100 + 32'(i), r); chk("R4", "A send response", 32'(r), 32'(OKAY));
        end
        bus_rd(0, 4'h8, d, r); chk("R6", "A status with words outgoing", d, 32'h1);
        bus_rd(1, 4'h8, d, r); chk("R6", "B status with words incoming", d, 32'h4);
        bus_wr(1, 4'h0, 32'hBEEF0001, r);
        bus_rd(0, 4'h4, d, r); chk("R2", "A receives from B", d, 32'hBEEF0001);
        for (int i = 0; i < 3; i++) begin
            bus_rd(1, 4'h4, d, r);
            chk("R2", "B receive order", d, 32'h1100 + 32'(i));
            chk("R2", "B receive response", 32'(r), 32'(OKAY));
        end
    endtask

    task automatic t_full();
        logic [31:0] d; logic [1:0] r;
        for (int i = 0; i < DEPTH; i++) bus_wr(0, 4'h0, 32'hA000 + 32'(i), r);
        bus_rd(0, 4'h8, d, r); chk("R3", "A status when full", d, 32'h9);
        bus_rd(1, 4'h8, d, r); chk("R3", "B status when full", d, 32'h6);
        bus_wr(0, 4'h0, 32'hDEAD, r); chk("R4", "write to full queue", 32'(r), 32'(SLVERR));
        for (int i = 0; i < DEPTH; i++) begin
            bus_rd(1, 4'h4, d, r); chk("R4", "contents after dropped write", d, 32'hA000 + 32'(i));
        end
        bus_rd(1, 4'h4, d, r);
        chk("R5", "empty read data", d, 0);
        chk("R5", "empty read response", 32'(r), 32'(SLVERR));
        bus_rd(1, 4'h8, d, r); chk("R5", "B status after empty read", d, 32'h5);
    endtask

    task automatic t_irq();
        logic [31:0] d; logic [1:0] r;
        bus_wr(0, 4'h0, 32'h77, r);
        chk("R8", "irq_b masked while disabled", 32'(irq_b), 0);
        bus_wr(1, 4'hC, 32'hFFFF_FFFF, r);
        bus_rd(1, 4'hC, d, r); chk("R7", "B enable readback", d, 1);
        chk("R8", "irq_b with word waiting", 32'(irq_b), 1);
        chk("R8", "irq_a stays low", 32'(irq_a), 0);
        bus_rd(1, 4'h4, d, r);
        chk("R8", "irq_b after drain", 32'(irq_b), 0);
        bus_wr(1, 4'hC, 32'h0, r);
        bus_rd(1, 4'hC, d, r); chk("R7", "B enable cleared", d, 0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d; logic [1:0] r, r2;
        bus_wr(0, 4'h0, 32'h5150, r);
        fork
            bus_wr(0, 4'h0, 32'h5151, r2);
            bus_rd(1, 4'h4, d, r);
        join
        chk("R9", "same-cycle write response", 32'(r2), 32'(OKAY));
        chk("R9", "same-cycle read data", d, 32'h5150);
        bus_rd(1, 4'h8, d, r); chk("R9", "one word left", d, 32'h4);
        bus_rd(1, 4'h4, d, r); chk("R9", "second word", d, 32'h5151);
        bus_rd(1, 4'h4, d, r); chk("R9", "queue empty after", 32'(r), 32'(SLVERR));
    endtask

    task automatic t_ignored();
        logic [31:0] d; logic [1:0] r;
        bus_wr(0, 4'h4, 32'h1234, r); chk("R11", "write to receive offset", 32'(r), 32'(OKAY));
        bus_wr(0, 4'h8, 32'hFFFF, r); chk("R11", "write to status offset", 32'(r), 32'(OKAY));
        bus_rd(0, 4'h8, d, r); chk("R11", "A status unchanged", d, 32'h5);
        bus_rd(1, 4'h8, d, r); chk("R11", "B status unchanged", d, 32'h5);
        chk("R11", "irq_b unchanged", 32'(irq_b), 0);
    endtask

    task automatic t_handshake();
        logic [31:0] d; logic [1:0] r;
        @(negedge clk);
        a_bready = 0; a_awaddr = 4'h0; a_wdata = 32'hC0DE; a_awvalid = 1; a_wvalid = 1;
        @(posedge clk);
        @(negedge clk);
        a_awaddr = 4'h0; a_wdata = 32'hC0DF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10", "response held", 32'(a_bvalid), 1);
            chk("R10", "no new accept while pending", 32'(a_awready), 0);
        end
        a_awvalid = 0; a_wvalid = 0; a_bready = 1;
        @(negedge clk);
        chk("R10", "response taken", 32'(a_bvalid), 0);
        bus_rd(1, 4'h4, d, r); chk("R10", "held write stored once", d, 32'hC0DE);
        bus_rd(1, 4'h4, d, r); chk("R10", "no duplicate", 32'(r), 32'(SLVERR));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_transfer();
        t_full();
        t_irq();
        t_same_cycle();
        t_ignored();
        t_handshake();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule